// File: doc/BRIEF.md
# Local Interrupt Controller Base and Mode Register

This block is the 64-bit control register that places a local interrupt controller's register window in physical memory. It also selects the controller's operating mode. The register holds four things: a 4 KiB-aligned base address, a bootstrap-processor flag, an enable bit and an extended-mode bit. Together the enable and extended bits give three legal modes: disabled, legacy (memory-mapped window) and extended.

Every write is checked in the same cycle it is presented. The check covers the mode-transition rules, the reserved-bit rules and the physical-address-width limit. A write that breaks any rule leaves every bit of the register unchanged and raises a fault pulse for that one cycle. The CPU's exception logic turns this pulse into a fault. A legal write is stored on the next clock edge.

The block also compares a probe address against the stored base. This tells the fabric whether an access falls inside the relocatable 4 KiB window. The window is live only in legacy mode.

Top module: `lic_base_ctl`

## Requirements
- R1: After reset the register reads as DEF_BASE (bits 12 and up, masked to PA_W), with enable (bit 11) set, extended (bit 10) clear, bootstrap flag (bit 8) equal to `bsp_strap`, and all other bits zero.
- R2: A write that breaks no rule keeps `fault` low, and `rd_data` equals the written value from the next cycle on.
- R3: A write with bit 10 set and bit 11 clear (invalid mode) faults, whatever the current mode.
- R4: From extended mode, a write selecting legacy mode (bit 11 set, bit 10 clear) faults. A write selecting disabled (both clear) is accepted.
- R5: From disabled mode, a write selecting extended mode (both bits set) faults. A write selecting legacy mode is accepted.
- R6: A write with any bit at position PA_W or above set faults.
- R7: A write with any of bits 0 to 7 or bit 9 set faults, including bit 0 alone.
- R8: While `ext_capable` is low, any write selecting extended mode faults.
- R9: `fault` is high in exactly the cycle where `wr_en` is high with an illegal value. After such a write the register is unchanged.
- R10: `win_hit` is high only in legacy mode, and only when `probe_addr[PA_W-1:12]` equals the stored base. After a legal base rewrite, the hit follows the new base and the old base no longer hits.
- R11: `mode_legacy` is high exactly when bit 11 is set and bit 10 is clear. `mode_ext` is high exactly when both are set. `bsp` mirrors bit 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bsp_strap | input | 1 | Bootstrap flag loaded at reset |
| ext_capable | input | 1 | High when extended mode is supported |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write value |
| rd_data | output | 64 | Current register value |
| fault | output | 1 | Illegal-write pulse, same cycle as the strobe |
| mode_legacy | output | 1 | Legacy (windowed) mode active |
| mode_ext | output | 1 | Extended mode active |
| bsp | output | 1 | Bootstrap-processor flag |
| probe_addr | input | PA_W | Physical address to match against the window |
| win_hit | output | 1 | Probe address lies in the 4 KiB window |

## Verification
The bench builds the block with PA_W = 40 and the default base. This leaves 24 upper address bits reserved, so the width check can be hit at its lowest bit (bit 40) and at bit 63. Bases up to 40 bits can be relocated and probed. Random writes mix all four enable/extended codes with occasional reserved bits and with `ext_capable` toggling. In this way every mode transition, legal and illegal, is visited from every starting mode.

// File: rtl/lic_base_ctl.sv
module lic_base_ctl #(
  parameter int          PA_W     = 36,
  parameter logic [63:0] DEF_BASE = 64'h0000_0000_FEE0_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bsp_strap,
  input  logic            ext_capable,
  input  logic            wr_en,
  input  logic [63:0]     wr_data,
  output logic [63:0]     rd_data,
  output logic            fault,
  output logic            mode_legacy,
  output logic            mode_ext,
  output logic            bsp,
  input  logic [PA_W-1:0] probe_addr,
  output logic            win_hit
);
  localparam int          BSP_B  = 8;
  localparam int          EXT_B  = 10;
  localparam int          EN_B   = 11;
  localparam logic [63:0] ADDR_M = ((64'd1 << PA_W) - 64'd1) & ~64'hFFF;
  localparam logic [63:0] CTRL_M = (64'd1 << BSP_B) | (64'd1 << EXT_B) | (64'd1 << EN_B);
  localparam logic [63:0] KEEP_M = ADDR_M | CTRL_M;

  logic [63:0] cur;
  logic        cur_en, cur_ext, nxt_en, nxt_ext;
  logic        bad_rsv, bad_mode, bad_cap;

  assign cur_en  = cur[EN_B];
  assign cur_ext = cur[EXT_B];
  assign nxt_en  = wr_data[EN_B];
  assign nxt_ext = wr_data[EXT_B];

  assign bad_rsv  = |(wr_data & ~KEEP_M);
  assign bad_cap  = nxt_ext && !ext_capable;
  assign bad_mode = (nxt_ext && !nxt_en)
                 || (cur_ext && nxt_en && !nxt_ext)
                 || (!cur_en && nxt_ext);

  assign fault = wr_en && (bad_rsv || bad_mode || bad_cap);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur <= (DEF_BASE & ADDR_M) | (64'd1 << EN_B) | (64'(bsp_strap) << BSP_B);
    else if (wr_en && !fault)
      cur <= wr_data;
  end

  assign rd_data     = cur;
  assign mode_legacy = cur_en && !cur_ext;
  assign mode_ext    = cur_en && cur_ext;
  assign bsp         = cur[BSP_B];
  assign win_hit     = mode_legacy && (probe_addr[PA_W-1:12] == cur[PA_W-1:12]);
endmodule

// File: rtl/lic_base_ctl_chk.sv
module lic_base_ctl_chk #(
  parameter int PA_W = 36
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [63:0] wr_data,
  input logic [63:0] rd_data,
  input logic        fault,
  input logic        mode_legacy,
  input logic        mode_ext,
  input logic        win_hit
);
  localparam logic [63:0] OK_M = (((64'd1 << PA_W) - 64'd1) & ~64'hFFF) | 64'hD00;

  p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !fault |=> rd_data == $past(wr_data));
  p_no_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data[10] && !rd_data[11]));
  p_ext_no_legacy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ext |=> !mode_legacy);
  p_off_no_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ext && !mode_legacy |=> !mode_ext);
  p_rsv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~OK_M) == 64'd0);
  p_fault_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> wr_en);
  p_keep_on_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> $stable(rd_data));
  p_hit_legacy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> mode_legacy);
  p_modes_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_legacy, mode_ext}));
endmodule

bind lic_base_ctl lic_base_ctl_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .fault(fault), .mode_legacy(mode_legacy),
  .mode_ext(mode_ext), .win_hit(win_hit)
);

// File: tb/test_lic_base_ctl.sv
module test_lic_base_ctl;
  localparam int          PERIOD = 10;
  localparam int          PA_W   = 40;
  localparam logic [63:0] DEFB   = 64'h0000_0000_FEE0_0000;
  localparam logic [63:0] KEEP   = (((64'd1 << PA_W) - 64'd1) & ~64'hFFF) | 64'hD00;

  logic clk = 0, rst_n = 0, bsp_strap = 1, cap = 1, wr_en = 0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic fault, mode_legacy, mode_ext, bsp, win_hit;
  logic [PA_W-1:0] probe_addr = '0;
  logic [63:0] model;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  lic_base_ctl #(.PA_W(PA_W), .DEF_BASE(DEFB)) i_lic_base_ctl (
    .clk(clk), .rst_n(rst_n), .bsp_strap(bsp_strap), .ext_capable(cap),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .fault(fault),
    .mode_legacy(mode_legacy), .mode_ext(mode_ext), .bsp(bsp),
    .probe_addr(probe_addr), .win_hit(win_hit)
  );

  function automatic logic exp_fault(logic [63:0] c, logic [63:0] d, logic k);
    logic en, ex;
    en = d[11]; ex = d[10];
    return (|(d & ~KEEP)) || (ex && !en) || (c[10] && en && !ex) || (!c[11] && ex) || (ex && !k);
  endfunction

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic chk_state(input string rq);
    chk(rq, "rd_data", rd_data, model);
    chk("R11", "mode_legacy", 64'(mode_legacy), 64'(model[11] && !model[10]));
    chk("R11", "mode_ext", 64'(mode_ext), 64'(model[11] && model[10]));
    chk("R11", "bsp", 64'(bsp), 64'(model[8]));
  endtask

  task automatic wr(input logic [63:0] d, input string rq);
    logic ef;
    ef = exp_fault(model, d, cap);
    @(negedge clk); wr_en = 1; wr_data = d; #1;
    chk(rq, "fault", 64'(fault), 64'(ef));
    @(negedge clk); wr_en = 0; wr_data = ~d;
    if (!ef) model = d;
    #1; chk_state(ef ? "R9" : rq);
    chk("R9", "fault idle", 64'(fault), 64'd0);
  endtask

  task automatic probe(input logic [PA_W-1:0] a, input string rq);
    probe_addr = a; #1;
    chk(rq, "win_hit", 64'(win_hit),
        64'(model[11] && !model[10] && a[PA_W-1:12] == model[PA_W-1:12]));
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [63:0] leg, ext, off, d;
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk);
    rst_n = 1;
    model = (DEFB & KEEP & ~64'hFFF) | 64'h900;
    #1; chk_state("R1");
    probe(DEFB[PA_W-1:0] + 40'h123, "R10");

    leg = model; ext = model | 64'h400; off = model & ~64'h800;
    wr(leg | 64'd1, "R7");
    wr(leg | 64'h200, "R7");
    wr(leg | (64'd1 << PA_W), "R6");
    wr(leg | (64'd1 << 63), "R6");
    wr(off | 64'h400, "R3");
    cap = 0; wr(ext, "R8"); cap = 1;
    wr(ext, "R2");
    probe(DEFB[PA_W-1:0], "R10");
    wr(leg, "R4");
    wr(off | 64'h400, "R3");
    wr(off, "R4");
    wr(ext, "R5");
    wr(leg, "R5");
    wr(64'h0000_00AB_CDEF_0900, "R10");
    probe(40'hAB_CDEF_0FFC, "R10");
    probe(DEFB[PA_W-1:0], "R10");

    for (int i = 0; i < 600; i++) begin
      d = {$urandom, $urandom} & KEEP & ~64'hC00;
      d[11] = $urandom_range(0, 1);
      d[10] = ($urandom_range(0, 2) == 0) ? ~d[11] : d[11];
      case ($urandom_range(0, 9))
        0: d |= 64'd1 << $urandom_range(0, 7);
        1: d |= 64'd1 << 9;
        2: d |= 64'd1 << $urandom_range(PA_W, 63);
        default: ;
      endcase
      cap = ($urandom_range(0, 7) != 0);
      wr(d, d[11] ? (d[10] ? "R5" : "R4") : (d[10] ? "R3" : "R2"));
      probe(($urandom_range(0, 1) == 1) ? {model[PA_W-1:12], 12'($urandom)}
                                        : PA_W'({$urandom, $urandom}), "R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule